// File: doc/BRIEF.md
# Sprite Attribute Memory Host Port

This block sits between a host bus and a 544-byte sprite attribute store that it holds itself. It folds every host address into the valid storage range. It stores host writes and returns host reads. While the picture is being drawn, it steers each host access to the address the renderer is using at that moment, not to the address the host gave.

Any write, steered or not, marks the renderer's cached sprite list as stale. The block clears a list-valid flag and, one cycle later, emits a pulse that carries the address and byte actually stored. This lets a downstream cache builder patch or rebuild its copy. The cache builder raises a done input once its rebuild is finished, and that sets the flag again.

Top module: `sprite_attr_port`

## Requirements
- R1: Only the low 10 bits of the 16-bit host address take part in addressing. The upper 6 bits have no effect on the storage location reached.
- R2: When bit 9 of the 10-bit address is 1, the address is reduced to bit 9 plus bits 4..0 (mask 0x21F), so values 0x200–0x3FF alias onto 32 bytes at 0x200–0x21F. The same folding applies to the internal renderer address.
- R3: While displayOff is 1, every access uses the folded host address, whatever the beam line is.
- R4: While displayOff is 0 and beamLine is below 225 (below 240 when overscan is 1), every access uses the folded internal address intAddr.
- R5: While displayOff is 0 and beamLine is 225 or more (240 or more with overscan), every access uses the folded host address.
- R6: A write stores hostWdata at the effective address on the clock edge. A read (hostRd=1, hostWr=0) loads the byte at the effective address into rdData on the edge. rdData holds its value in every other cycle, including cycles with hostRd and hostWr both 1, where the write wins.
- R7: listValid is 0 after reset. It goes to 0 on the edge of any write. It goes to 1 on an edge where rebuildDone is 1 and no write happens.
- R8: cacheInval is a one-cycle pulse in the cycle after each write cycle. During that pulse, updAddr and updData hold the effective address and data of that write.
- R9: ramEn equals hostRd OR hostWr, and ramWe equals hostWr. ramAddr never exceeds 0x21F while ramEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 16 | Host byte address before folding |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write byte |
| intAddr | input | 10 | Renderer's current internal address |
| beamLine | input | 9 | Current scan line |
| overscan | input | 1 | 1 selects the 240-line active region |
| displayOff | input | 1 | 1 when the picture is blanked by force |
| rebuildDone | input | 1 | Cache builder has finished rebuilding |
| rdData | output | 8 | Registered read byte |
| ramAddr | output | 10 | Effective storage address this cycle |
| ramEn | output | 1 | Storage access this cycle |
| ramWe | output | 1 | Storage write this cycle |
| cacheInval | output | 1 | One-cycle pulse after each write |
| updAddr | output | 10 | Address stored by the reported write |
| updData | output | 8 | Byte stored by the reported write |
| listValid | output | 1 | Sprite list cache is current |

## Verification
On every cycle, the assertions check several properties. The effective address stays within the storage. Steering never happens while the display is forced off. A write always clears the valid flag and produces the following report pulse with the stored address. rdData stays stable when no read occurs. Only the bench's scenarios can show what ends up where in storage. It sweeps all 1024 folded host addresses and compares the readback with an arithmetic model. It also exercises the line thresholds on both sides in both overscan settings. It checks the read and write collision and the race between a write and rebuildDone.

// File: rtl/sap_pkg.sv
package sap_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic useInt;  // select the renderer address
    logic doRd;    // load read register
    logic doWr;    // store write byte
  } sapStrobe_t;
endpackage

// File: rtl/sap_fold.sv
module sap_fold #(
  parameter int IN_W      = 16,
  parameter int ADDR_W    = 10,
  parameter int HIGH_BIT  = 9,
  parameter int HIGH_SPAN = 32
) (
  input  logic [IN_W-1:0]   rawAddr,
  output logic [ADDR_W-1:0] foldAddr
);
  localparam logic [ADDR_W-1:0] HIGH_KEEP =
    ADDR_W'((1 << HIGH_BIT) | (HIGH_SPAN - 1));

  logic [ADDR_W-1:0] lowAddr;
  assign lowAddr = rawAddr[ADDR_W-1:0];

  generate
    if (IN_W > ADDR_W) begin : g_wide
      logic unusedHigh;
      assign unusedHigh = ^rawAddr[IN_W-1:ADDR_W];
    end
  endgenerate

  always_comb begin
    if (lowAddr[HIGH_BIT]) foldAddr = lowAddr & HIGH_KEEP;
    else                   foldAddr = lowAddr;
  end
endmodule

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int STD_LINES = 225,
  parameter int OS_LINES  = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [LINE_W-1:0] beamLine,
  input  logic              overscan,
  input  logic              displayOff,
  input  logic              rebuildDone,
  output sapStrobe_t        strobe,
  output logic              listValid
);
  localparam logic [LINE_W-1:0] STD_LIM = LINE_W'(STD_LINES);
  localparam logic [LINE_W-1:0] OS_LIM  = LINE_W'(OS_LINES);

  logic [LINE_W-1:0] lineLimit;
  logic              inActive;

  assign lineLimit = overscan ? OS_LIM : STD_LIM;
  assign inActive  = !displayOff && (beamLine < lineLimit);

  always_comb begin
    strobe.useInt = inActive;
    strobe.doWr   = hostWr;
    strobe.doRd   = hostRd && !hostWr;
  end

  // write clears, rebuild completion sets; write wins
  always_ff @(posedge clk) begin
    if (!rstN)            listValid <= 1'b0;
    else if (hostWr)      listValid <= 1'b0;
    else if (rebuildDone) listValid <= 1'b1;
  end

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> !listValid);
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rebuildDone && !hostWr) |=> listValid);
  a_r3_no_steer_when_off: assert property (@(posedge clk) disable iff (!rstN)
    displayOff |-> !strobe.useInt);
endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
#(
  parameter int HOST_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int HIGH_BIT  = 9,
  parameter int HIGH_SPAN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sapStrobe_t        strobe,
  input  logic [HOST_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] intAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramEn,
  output logic              ramWe,
  output logic              cacheInval,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] updData
);
  localparam int DEPTH = (1 << HIGH_BIT) + HIGH_SPAN;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] hostFold;
  logic [ADDR_W-1:0] intFold;
  logic [DATA_W-1:0] mem [DEPTH];

  sap_fold #(.IN_W(HOST_W), .ADDR_W(ADDR_W), .HIGH_BIT(HIGH_BIT),
             .HIGH_SPAN(HIGH_SPAN)) i_hostFold (
    .rawAddr(hostAddr), .foldAddr(hostFold));

  sap_fold #(.IN_W(ADDR_W), .ADDR_W(ADDR_W), .HIGH_BIT(HIGH_BIT),
             .HIGH_SPAN(HIGH_SPAN)) i_intFold (
    .rawAddr(intAddr), .foldAddr(intFold));

  assign ramAddr = strobe.useInt ? intFold : hostFold;
  assign ramEn   = strobe.doRd || strobe.doWr;
  assign ramWe   = strobe.doWr;

  always_ff @(posedge clk) begin
    if (strobe.doWr) mem[ramAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      cacheInval <= 1'b0;
      updAddr    <= '0;
      updData    <= '0;
    end else begin
      if (strobe.doRd) rdData <= mem[ramAddr];
      cacheInval <= strobe.doWr;
      if (strobe.doWr) begin
        updAddr <= ramAddr;
        updData <= wrData;
      end
    end
  end

  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    ramEn |-> (ramAddr <= TOP_ADDR));
  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWr |=> cacheInval);
  a_r8_no_pulse_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doWr |=> !cacheInval);
  a_r8_report_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWr |=> (updAddr == $past(ramAddr)));
  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doRd |=> $stable(rdData));
endmodule

// File: rtl/sprite_attr_port.sv
module sprite_attr_port
  import sap_pkg::*;
#(
  parameter int HOST_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int HIGH_BIT  = 9,
  parameter int HIGH_SPAN = 32,
  parameter int STD_LINES = 225,
  parameter int OS_LINES  = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HOST_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] intAddr,
  input  logic [LINE_W-1:0] beamLine,
  input  logic              overscan,
  input  logic              displayOff,
  input  logic              rebuildDone,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramEn,
  output logic              ramWe,
  output logic              cacheInval,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] updData,
  output logic              listValid
);
  sapStrobe_t strobe;

  sap_ctrl #(.LINE_W(LINE_W), .STD_LINES(STD_LINES), .OS_LINES(OS_LINES)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .beamLine(beamLine), .overscan(overscan), .displayOff(displayOff),
    .rebuildDone(rebuildDone), .strobe(strobe), .listValid(listValid));

  sap_datapath #(.HOST_W(HOST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .HIGH_BIT(HIGH_BIT), .HIGH_SPAN(HIGH_SPAN)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .intAddr(intAddr), .wrData(hostWdata), .rdData(rdData),
    .ramAddr(ramAddr), .ramEn(ramEn), .ramWe(ramWe),
    .cacheInval(cacheInval), .updAddr(updAddr), .updData(updData));
endmodule

// File: tb/test_sprite_attr_port.sv
module test_sprite_attr_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [9:0] intAddr = '0;
  logic [8:0] beamLine = '0;
  logic overscan = 1'b0, displayOff = 1'b1, rebuildDone = 1'b0;
  logic [7:0] rdData;
  logic [9:0] ramAddr, updAddr;
  logic ramEn, ramWe, cacheInval, listValid;
  logic [7:0] updData;

  int total = 0;
  int bad = 0;
  int model [544];

  sprite_attr_port i_sprite_attr_port (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .intAddr(intAddr), .beamLine(beamLine),
    .overscan(overscan), .displayOff(displayOff), .rebuildDone(rebuildDone),
    .rdData(rdData), .ramAddr(ramAddr), .ramEn(ramEn), .ramWe(ramWe),
    .cacheInval(cacheInval), .updAddr(updAddr), .updData(updData),
    .listValid(listValid));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int foldOf(input int a);
    int t = a % 1024;
    return (t >= 512) ? 512 + (t % 32) : t;
  endfunction

  function automatic int effOf(input int ha, input int ia, input int line,
                               input bit os, input bit off);
    bit act = !off && (line < (os ? 240 : 225));
    return act ? foldOf(ia) : foldOf(ha);
  endfunction

  // one access cycle; checks address, strobes, then registered results
  task automatic access(input bit wr, input bit rd, input int ha, input int ia,
                        input int d, input int line, input bit os, input bit off,
                        input string req);
    int eff = effOf(ha, ia, line, os, off);
    int prevRd;
    @(negedge clk);
    prevRd = rdData;
    hostAddr = 16'(ha); intAddr = 10'(ia); hostWdata = 8'(d);
    beamLine = 9'(line); overscan = os; displayOff = off;
    hostWr = wr; hostRd = rd;
    #1;
    chk(ramAddr == 10'(eff), req, ramAddr, eff);
    chk(ramEn == (wr | rd) && ramWe == wr, "R9", {ramEn, ramWe}, {wr | rd, wr});
    @(posedge clk); #1;
    if (wr) begin
      model[eff] = d;
      chk(cacheInval, "R8", cacheInval, 1);
      chk(updAddr == 10'(eff) && updData == 8'(d), "R8", updAddr, eff);
      chk(!listValid, "R7", listValid, 0);
      if (rd) chk(rdData == 8'(prevRd), "R6", rdData, prevRd);
    end else if (rd) begin
      chk(rdData == 8'(model[eff]), req, rdData, model[eff]);
    end
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(rdData == 0, "R6 reset", rdData, 0);
    chk(!cacheInval, "R8 reset", cacheInval, 0);
    chk(!listValid, "R7 reset", listValid, 0);
    chk(!ramEn, "R9 idle", ramEn, 0);

    // R1/R2 sweep: all 1024 low addresses, random-ish upper bits
    for (int a = 0; a < 1024; a++)
      access(1, 0, a | ((a * 37) & 16'hFC00), 0, (a * 7 + 3) & 255, 0, 0, 1, "R2");
    for (int a = 0; a < 1024; a++)
      access(0, 1, a | ((a * 91) & 16'hFC00), 0, 0, 0, 0, 1, "R1");

    // steering thresholds: R3 R4 R5
    access(1, 0, 16'h0123, 10'h2A5, 8'h11, 100, 0, 1, "R3");
    access(1, 0, 16'h0123, 10'h2A5, 8'h22, 0,   0, 0, "R4");
    access(1, 0, 16'h0133, 10'h077, 8'h33, 224, 0, 0, "R4");
    access(1, 0, 16'h0144, 10'h078, 8'h44, 225, 0, 0, "R5");
    access(1, 0, 16'h0155, 10'h079, 8'h55, 239, 1, 0, "R4");
    access(1, 0, 16'h0166, 10'h07A, 8'h66, 240, 1, 0, "R5");
    access(1, 0, 16'hF3E1, 10'h07B, 8'h77, 500, 0, 0, "R5");
    access(0, 1, 16'h0123, 10'h2A5, 0,     10,  0, 0, "R4");
    access(0, 1, 16'h0123, 10'h2A5, 0,     300, 1, 0, "R5");
    access(0, 1, 16'h0144, 10'h077, 0,     230, 1, 0, "R4");
    access(0, 1, 16'h0166, 10'h07A, 0,     0,   1, 1, "R3");

    // R6 collision: write wins, rdData holds
    access(1, 1, 16'h0010, 0, 8'h9C, 0, 0, 1, "R6");
    access(0, 1, 16'h0010, 0, 0,     0, 0, 1, "R6");

    // R7 valid flag
    @(negedge clk); rebuildDone = 1'b1;
    @(posedge clk); #1;
    chk(listValid, "R7 set", listValid, 1);
    chk(!cacheInval, "R8 idle", cacheInval, 0);
    @(negedge clk); rebuildDone = 1'b0;
    hostWr = 1'b1; hostAddr = 16'h0020; hostWdata = 8'h5A; displayOff = 1'b1;
    rebuildDone = 1'b1;
    @(posedge clk); #1;
    model[32] = 8'h5A;
    chk(!listValid, "R7 race", listValid, 0);
    @(negedge clk); hostWr = 1'b0;
    @(posedge clk); #1;
    chk(listValid, "R7 reset by done", listValid, 1);
    chk(!cacheInval, "R8 single pulse", cacheInval, 0);
    @(negedge clk); rebuildDone = 1'b0;
    access(1, 0, 16'h0021, 0, 8'hA5, 50, 0, 1, "R7");
    access(0, 1, 16'h0020, 0, 0, 50, 0, 1, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule